// File: doc/BRIEF.md
# Supervisory Reset Pulse Controller

This block produces a single, stretched system reset from three independent requests. The first is a digitized supply-good flag from an external threshold comparator. The second is a shared reset pin that this block pulls low and that other devices on the board can also pull low. The third is an active-low pushbutton input. Every request leads to the same output: a drive-enable for an open-drain pad (`pin_drive_o` high pulls the pin low). That output stays asserted for at least a parameterized number of clock cycles after the last request goes away.

All three inputs are asynchronous. Each passes through a two-flop synchronizer before any further logic. The supply flag and the pushbutton each have a glitch filter. Either one holds reset for as long as it stays low. The shared pin works differently because it is edge-triggered: only a falling edge counts, and the pulse it starts always lasts one full timeout, no matter how long the pin is held low. While the block drives the pin itself, the falling edges that its own drive creates are masked. A request that arrives while a timeout is running restarts the count from zero.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst` is high, `pin_drive_o` is 1. After `rst` falls, with no request present, it stays 1 for exactly TIMEOUT cycles and then goes to 0.
- R2: A low on `supply_ok_i` held for L >= SUP_FILT cycles asserts the drive SUP_FILT+3 cycles after the fall. The pulse lasts L - SUP_FILT + TIMEOUT cycles.
- R3: A low on `supply_ok_i` shorter than SUP_FILT cycles produces no reset pulse.
- R4: A high-to-low transition on `pin_sense_i` that is not caused by the block asserts the drive 3 cycles later. The pulse lasts exactly TIMEOUT cycles whether the external low lasted 1 cycle or longer than TIMEOUT.
- R5: A low on `button_n_i` held for L >= BTN_FILT cycles asserts the drive BTN_FILT+3 cycles after the fall. The pulse lasts L - BTN_FILT + TIMEOUT cycles, so reset covers the whole press plus one timeout.
- R6: A low on `button_n_i` shorter than BTN_FILT cycles produces no reset pulse.
- R7: Pin falling edges that occur while `pin_drive_o` is 1 are not triggers. A reset caused by the supply flag, the button or `rst` yields exactly one pulse and no follow-on pulse.
- R8: A request that arrives during a running timeout restarts the count at zero. This includes a request seen in the very cycle the count would expire, in which case the drive shows no gap.
- R9: The drive is released only after TIMEOUT consecutive cycles with no request. When no request is present it stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; forces the drive on |
| supply_ok_i | input | 1 | Asynchronous supply-good flag, 1 = above threshold |
| pin_sense_i | input | 1 | Asynchronous sensed level of the shared reset pin |
| button_n_i | input | 1 | Asynchronous pushbutton, active low |
| pin_drive_o | output | 1 | Open-drain drive enable, 1 = pull the reset pin low |

## Verification
The two functions that can coincide are timeout expiry and the arrival of a new request. A pin-started pulse is launched, and a filtered button press is timed so that its flag reaches the stretcher on exactly the edge where the count reaches its final value. The pulse is judged by its measured width. A restart that wins gives one unbroken pulse of 2*TIMEOUT cycles. A lost restart would show as a one-cycle gap, which the monitor sees as two separate pulses. A second case places the button request well inside a pin-started timeout to check an ordinary restart.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    // Stretcher state: idle (pin released), held by a level source, counting.
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_HOLD  = 2'd1,
        RS_COUNT = 2'd2
    } rs_state_e;

    // Raw and synchronized input levels, idle value all ones.
    typedef struct packed {
        logic supply_ok;
        logic pin_hi;
        logic button_hi;
    } rs_pins_t;

    // Qualified requests handed to the stretcher.
    typedef struct packed {
        logic supply_low;
        logic button_low;
        logic pin_fall;
    } rs_trig_t;

    localparam int unsigned MIN_TIMEOUT = 4;

    // Bits needed to hold values 0 .. n-1.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic logic level_request(input rs_trig_t t);
        return t.supply_low | t.button_low;
    endfunction

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int unsigned W       = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain;

    initial begin
        assert (STAGES >= 2) else $error("rsup_sync needs at least two stages");
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rsup_glitch_filt.sv
module rsup_glitch_filt #(
    parameter int unsigned FILT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic level_i,   // synchronized, 1 = idle
    output logic low_o      // 1 once level_i was low FILT cycles in a row
);
    import rsup_pkg::*;

    localparam int unsigned RUN_W = cnt_width(FILT + 1);
    localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(FILT);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT - 1);

    logic [RUN_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= '0;
            low_o <= 1'b0;
        end else if (level_i) begin
            run   <= '0;
            low_o <= 1'b0;
        end else begin
            if (run != RUN_MAX) begin
                run <= run + 1'b1;
            end
            if (run == RUN_LAST) begin
                low_o <= 1'b1;
            end
        end
    end

    AST_FILT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        level_i |=> !low_o); // R5
    AST_FILT_MIN_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(low_o) |-> ($past(run) == RUN_LAST && !$past(level_i))); // R3
endmodule

// File: rtl/rsup_fall_det.sv
module rsup_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic level_i,   // synchronized pin level
    input  logic mask_i,    // block is driving the pin itself
    output logic fall_o
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b1;
        end else begin
            prev <= level_i;
        end
    end

    assign fall_o = prev & ~level_i & ~mask_i;

    AST_SELF_MASK: assert property (@(posedge clk) disable iff (rst)
        mask_i |-> !fall_o); // R7
endmodule

// File: rtl/rsup_stretch.sv
module rsup_stretch #(
    parameter int unsigned TIMEOUT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  rsup_pkg::rs_trig_t trig_i,
    output logic              drive_o
);
    import rsup_pkg::*;

    localparam int unsigned CNT_W = cnt_width(TIMEOUT);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    rs_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic             hold;

    initial begin
        assert (TIMEOUT >= MIN_TIMEOUT) else $error("TIMEOUT too short for pin masking");
    end

    assign hold = level_request(trig_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RS_COUNT;
            cnt   <= '0;
        end else if (hold) begin
            state <= RS_HOLD;
            cnt   <= '0;
        end else if (trig_i.pin_fall) begin
            state <= RS_COUNT;
            cnt   <= '0;
        end else begin
            unique case (state)
                RS_IDLE: begin
                    cnt <= '0;
                end
                RS_HOLD, RS_COUNT: begin
                    if (cnt == CNT_LAST) begin
                        state <= RS_IDLE;
                        cnt   <= '0;
                    end else begin
                        state <= RS_COUNT;
                        cnt   <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= RS_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign drive_o = (state != RS_IDLE);

    AST_HOLD_DRIVES: assert property (@(posedge clk) disable iff (rst)
        hold |=> drive_o); // R5
    AST_FALL_RESTART: assert property (@(posedge clk) disable iff (rst)
        trig_i.pin_fall |=> (drive_o && cnt == '0)); // R8
    AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(drive_o) |-> ($past(cnt) == CNT_LAST && !$past(hold) && !$past(trig_i.pin_fall))); // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_LAST); // R9
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!drive_o && !hold && !trig_i.pin_fall) |=> !drive_o); // R9
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int unsigned SUP_FILT    = 4,
    parameter int unsigned BTN_FILT    = 6,
    parameter int unsigned TIMEOUT     = 40,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok_i,
    input  logic pin_sense_i,
    input  logic button_n_i,
    output logic pin_drive_o
);
    import rsup_pkg::*;

    localparam int unsigned PIN_W = $bits(rs_pins_t);

    rs_pins_t raw;
    rs_pins_t synced;
    rs_trig_t trig;
    logic     drive;

    assign raw = '{supply_ok: supply_ok_i, pin_hi: pin_sense_i, button_hi: button_n_i};

    rsup_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({PIN_W{1'b1}})
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw),
        .q_o (synced)
    );

    rsup_glitch_filt #(.FILT(SUP_FILT)) u_sup_filt (
        .clk     (clk),
        .rst     (rst),
        .level_i (synced.supply_ok),
        .low_o   (trig.supply_low)
    );

    rsup_glitch_filt #(.FILT(BTN_FILT)) u_btn_filt (
        .clk     (clk),
        .rst     (rst),
        .level_i (synced.button_hi),
        .low_o   (trig.button_low)
    );

    rsup_fall_det u_pin_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (synced.pin_hi),
        .mask_i  (drive),
        .fall_o  (trig.pin_fall)
    );

    rsup_stretch #(.TIMEOUT(TIMEOUT)) u_stretch (
        .clk     (clk),
        .rst     (rst),
        .trig_i  (trig),
        .drive_o (drive)
    );

    assign pin_drive_o = drive;

    AST_RST_DRIVES: assert property (@(posedge clk)
        $past(rst) |-> pin_drive_o); // R1
endmodule

// File: tb/sim_rst_supervisor.sv
module sim_rst_supervisor;
    localparam int T  = 40;
    localparam int SF = 4;
    localparam int BF = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b1;
    logic ext_low = 1'b0;
    logic button_n = 1'b1;
    logic pin_drive;
    logic pin_sense;

    assign pin_sense = !(pin_drive || ext_low);

    always #2 clk = ~clk;

    rst_supervisor #(.SUP_FILT(SF), .BTN_FILT(BF), .TIMEOUT(T)) u0 (
        .clk         (clk),
        .rst         (rst),
        .supply_ok_i (supply_ok),
        .pin_sense_i (pin_sense),
        .button_n_i  (button_n),
        .pin_drive_o (pin_drive)
    );

    int    exp_w[$];
    string exp_tag[$];
    int    tests = 0;
    int    fails = 0;
    bit    mon_on = 0;
    bit    in_pulse = 0;
    int    width = 0;
    int    e_w;
    string e_tag;

    task automatic push(input int w, input string tag);
        exp_w.push_back(w);
        exp_tag.push_back(tag);
    endtask

    // Monitor: measures every drive pulse and compares it with the queue head.
    always @(negedge clk) begin
        if (mon_on) begin
            if (pin_drive) begin
                width    = in_pulse ? width + 1 : 1;
                in_pulse = 1;
            end else if (in_pulse) begin
                in_pulse = 0;
                tests++;
                if (exp_w.size() == 0) begin
                    fails++;
                    $display("FAIL R7: unexpected pulse of width %0d, expected none", width);
                end else begin
                    e_w   = exp_w.pop_front();
                    e_tag = exp_tag.pop_front();
                    if (width != e_w) begin
                        fails++;
                        $display("FAIL %s: pulse width %0d, expected %0d", e_tag, width, e_w);
                    end
                end
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic check_idle(input string tag);
        @(negedge clk);
        tests++;
        if (pin_drive !== 1'b0 || in_pulse || exp_w.size() != 0) begin
            fails++;
            $display("FAIL %s: drive=%0b pending=%0d, expected drive=0 pending=0",
                     tag, pin_drive, exp_w.size());
        end
    endtask

    task automatic sup_dip(input int n);
        @(posedge clk); #1 supply_ok = 1'b0;
        repeat (n) @(posedge clk);
        #1 supply_ok = 1'b1;
    endtask

    task automatic btn_press(input int n);
        @(posedge clk); #1 button_n = 1'b0;
        repeat (n) @(posedge clk);
        #1 button_n = 1'b1;
    endtask

    task automatic pin_pull(input int n);
        @(posedge clk); #1 ext_low = 1'b1;
        repeat (n) @(posedge clk);
        #1 ext_low = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++;
        if (pin_drive !== 1'b1) begin
            fails++;
            $display("FAIL R1: drive during reset %0b, expected 1", pin_drive);
        end
        @(posedge clk); #1 rst = 1'b0; mon_on = 1;
        push(T, "R1");
        cycles(T + 20);
        check_idle("R1");

        sup_dip(SF - 1);                    // R3 glitch
        cycles(40);
        check_idle("R3");

        push(T, "R2");                      // shortest accepted dip
        sup_dip(SF);
        cycles(T + 20);
        check_idle("R7");                   // self-driven pin fall gave no second pulse

        push(10 - SF + T, "R2");
        sup_dip(10);
        cycles(T + 20);
        check_idle("R2");

        btn_press(BF - 1);                  // R6 glitch
        cycles(40);
        check_idle("R6");

        push(T, "R5");
        btn_press(BF);
        cycles(T + 20);
        push(20 - BF + T, "R5");
        btn_press(20);
        cycles(T + 20);
        check_idle("R5");

        push(T, "R4");                      // one-cycle external pull
        pin_pull(1);
        cycles(T + 20);
        push(T, "R4");                      // pull longer than the timeout
        pin_pull(T + 20);
        cycles(T + 20);
        check_idle("R4");

        // R8: button request well inside a pin-started timeout
        push(10 + 8 + T, "R8");
        @(posedge clk);
        fork
            begin #1 ext_low = 1'b1; repeat (2) @(posedge clk); #1 ext_low = 1'b0; end
            begin repeat (10) @(posedge clk); #1 button_n = 1'b0;
                  repeat (8) @(posedge clk); #1 button_n = 1'b1; end
        join
        cycles(T + 20);
        check_idle("R8");

        // R8: button flag reaches the stretcher on the expiry edge
        push((T - BF) + BF + T, "R8");
        @(posedge clk);
        fork
            begin #1 ext_low = 1'b1; repeat (2) @(posedge clk); #1 ext_low = 1'b0; end
            begin repeat (T - BF) @(posedge clk); #1 button_n = 1'b0;
                  repeat (BF) @(posedge clk); #1 button_n = 1'b1; end
        join
        cycles(T + 20);
        check_idle("R9");

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: run still active, expected completion");
        finish_run();
    end
endmodule